// File: doc/BRIEF.md
# Fast System Return State Unit

This unit computes the architectural state that a processor takes on when a kernel system-call handler hands control back to user code at privilege level 3. A one-cycle request carries the saved return address (the link register), the saved flags image, a selector configuration word, a shadow-stack enable and the user-level shadow-stack pointer. One cycle later the unit either commits the new instruction pointer, flags, code and stack selectors, fixed descriptor attributes, execution mode, privilege level and shadow-stack pointer, or it signals a general-protection fault (error code zero) and commits nothing.

The operand-size input chooses between a return that stays in 64-bit mode and a return to 32-bit compatibility mode, in which only the low halves of the link register and flags image are used. Selector values are derived from the top field of the configuration word. No descriptor table is read, and the stack pointer is not touched.

Control is a three-state machine. ST_IDLE is the state with no response pending. From any state, a request moves it to ST_DONE (commit) or to ST_FAULT (rejected); with no request it goes to ST_IDLE. ST_DONE and ST_FAULT each last exactly one cycle, so every request produces one pulse, and requests may arrive back to back.

Top module: `fast_return_unit`

## Requirements
- R1: On a committed 64-bit return, ip_o equals link_i.
- R2: On a committed compatibility return (op64_i=0), ip_o is link_i[31:0] zero-extended and mode64_o is 0; a committed 64-bit return sets mode64_o to 1.
- R3: With base = sel_cfg_i[63:48], code_sel_o is base+16 for a 64-bit return and base for a compatibility return; stack_sel_o is base+8; sums wrap modulo 2^16.
- R4: Bits 1:0 of code_sel_o and stack_sel_o are 2'b11 after every commit.
- R5: Attribute words are packed {G[10],D[9],L[8],P[7],DPL[6:5],S[4],TYPE[3:0]}: code_attr_o is 11'h5FB for 64-bit and 11'h6FB for compatibility; stack_attr_o is 11'h6F3.
- R6: flags_o is flags_src_i with bits 3, 5, 15, 16, 17 and 63:22 cleared and bit 1 set; all other bits pass through.
- R7: A 64-bit request whose link_i[63:47] bits are not all equal produces fault_o and leaves every state output unchanged.
- R8: A compatibility request never faults, whatever link_i[63:32] holds.
- R9: When shstk_en_i=1 a commit loads ssp_o from user_ssp_i; when 0, ssp_o keeps its value.
- R10: cpl_o is 0 after reset and 3 after any commit.
- R11: Exactly one of done_o or fault_o pulses for one cycle, the cycle after each request (also for back-to-back requests); neither pulses without a request.
- R12: After reset done_o, fault_o, ip_o, flags_o, selectors, attributes, mode64_o and ssp_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle return request |
| op64_i | input | 1 | 1: stay in 64-bit mode, 0: compatibility mode |
| link_i | input | 64 | Saved return address |
| flags_src_i | input | 64 | Saved flags image |
| sel_cfg_i | input | 64 | Configuration word, selector base in [63:48] |
| shstk_en_i | input | 1 | User-level shadow stack enabled |
| user_ssp_i | input | 64 | User-level shadow-stack pointer |
| done_o | output | 1 | Commit pulse |
| fault_o | output | 1 | General-protection fault pulse (error code 0) |
| ip_o | output | 64 | Committed instruction pointer |
| flags_o | output | 64 | Committed flags |
| code_sel_o | output | 16 | Committed code selector |
| stack_sel_o | output | 16 | Committed stack selector |
| code_attr_o | output | 11 | Code descriptor attributes |
| stack_attr_o | output | 11 | Stack descriptor attributes |
| mode64_o | output | 1 | 1 when in 64-bit mode |
| cpl_o | output | 2 | Current privilege level |
| ssp_o | output | 64 | Shadow-stack pointer |

## Verification
Every cycle the assertions check the request-to-pulse timing and mutual exclusion, the forced selector and flag bits on commits, the privilege level after a commit, the zero upper half of a compatibility pointer, and that a fault changes no state. Exact selector arithmetic including wraparound, the attribute encodings for each mode, the canonical boundary on both sides, the shadow-stack hold when disabled and correct ordering of back-to-back requests are shown only by the bench's scenarios against its scoreboard.

// File: rtl/fret_pkg.sv
package fret_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } fret_state_e;

    typedef struct packed {
        logic       g;
        logic       d;
        logic       l;
        logic       p;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] typ;
    } seg_attr_t;

    localparam int ATTR_W = $bits(seg_attr_t);

    localparam seg_attr_t CODE_ATTR_64 =
        '{g: 1'b1, d: 1'b0, l: 1'b1, p: 1'b1, dpl: 2'd3, s: 1'b1, typ: 4'hB};
    localparam seg_attr_t CODE_ATTR_32 =
        '{g: 1'b1, d: 1'b1, l: 1'b0, p: 1'b1, dpl: 2'd3, s: 1'b1, typ: 4'hB};
    localparam seg_attr_t STACK_ATTR =
        '{g: 1'b1, d: 1'b1, l: 1'b0, p: 1'b1, dpl: 2'd3, s: 1'b1, typ: 4'h3};

endpackage

// File: rtl/fret_canon.sv
module fret_canon #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48
) (
    input  logic [XLEN-1:0] addr_i,
    output logic            canon_o
);
    localparam int NTOP = XLEN - VA_BITS + 1;

    logic [NTOP-1:0] same;

    for (genvar i = 0; i < NTOP; i++) begin : g_cmp
        assign same[i] = (addr_i[VA_BITS-1+i] == addr_i[VA_BITS-1]);
    end

    assign canon_o = &same;
endmodule

// File: rtl/fret_flagfix.sv
module fret_flagfix #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src_i,
    output logic [XLEN-1:0] flags_o
);
    localparam int          LIVE_W = 22;
    localparam logic [XLEN-1:0] KEEP_MASK = {{(XLEN-LIVE_W){1'b0}}, 22'h3C7FD5};
    localparam logic [XLEN-1:0] ONE_MASK  = XLEN'(2);

    assign flags_o = (src_i & KEEP_MASK) | ONE_MASK;
endmodule

// File: rtl/fret_selgen.sv
module fret_selgen #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] base_i,
    input  logic             op64_i,
    output logic [SEL_W-1:0] code_sel_o,
    output logic [SEL_W-1:0] stack_sel_o
);
    localparam logic [SEL_W-1:0] CODE64_OFF = SEL_W'(16);
    localparam logic [SEL_W-1:0] STACK_OFF  = SEL_W'(8);
    localparam logic [SEL_W-1:0] RPL3       = SEL_W'(3);

    logic [SEL_W-1:0] code_raw;
    logic [SEL_W-1:0] stack_raw;

    assign code_raw    = op64_i ? (base_i + CODE64_OFF) : base_i;
    assign stack_raw   = base_i + STACK_OFF;
    assign code_sel_o  = code_raw | RPL3;
    assign stack_sel_o = stack_raw | RPL3;
endmodule

// File: rtl/fast_return_unit.sv
module fast_return_unit
    import fret_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48,
    parameter int SEL_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                op64_i,
    input  logic [XLEN-1:0]     link_i,
    input  logic [XLEN-1:0]     flags_src_i,
    input  logic [XLEN-1:0]     sel_cfg_i,
    input  logic                shstk_en_i,
    input  logic [XLEN-1:0]     user_ssp_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [XLEN-1:0]     ip_o,
    output logic [XLEN-1:0]     flags_o,
    output logic [SEL_W-1:0]    code_sel_o,
    output logic [SEL_W-1:0]    stack_sel_o,
    output logic [ATTR_W-1:0]   code_attr_o,
    output logic [ATTR_W-1:0]   stack_attr_o,
    output logic                mode64_o,
    output logic [1:0]          cpl_o,
    output logic [XLEN-1:0]     ssp_o
);
    localparam int HALF = XLEN / 2;

    fret_state_e state_q, state_d;

    logic             canon;
    logic             reject;
    logic             commit;
    logic [XLEN-1:0]  flags_fixed;
    logic [XLEN-1:0]  ip_next;
    logic [SEL_W-1:0] cs_next, ss_next;
    logic             cfg_unused;

    assign cfg_unused = ^sel_cfg_i[XLEN-SEL_W-1:0];

    fret_canon #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
        .addr_i  (link_i),
        .canon_o (canon)
    );

    fret_flagfix #(.XLEN(XLEN)) u_flagfix (
        .src_i   (flags_src_i),
        .flags_o (flags_fixed)
    );

    fret_selgen #(.SEL_W(SEL_W)) u_selgen (
        .base_i      (sel_cfg_i[XLEN-1 -: SEL_W]),
        .op64_i      (op64_i),
        .code_sel_o  (cs_next),
        .stack_sel_o (ss_next)
    );

    assign reject  = op64_i && !canon;
    assign commit  = req_i && !reject;
    assign ip_next = op64_i ? link_i : {{HALF{1'b0}}, link_i[HALF-1:0]};

    // next-state logic: every state responds to a new request the same way
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (req_i) state_d = reject ? ST_FAULT : ST_DONE;
                else       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pulse outputs decoded from the state
    always_comb begin
        done_o  = 1'b0;
        fault_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  done_o  = 1'b1;
            ST_FAULT: fault_o = 1'b1;
            default:  ;
        endcase
    end

    // architectural state, written only on a commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_o         <= '0;
            flags_o      <= '0;
            code_sel_o   <= '0;
            stack_sel_o  <= '0;
            code_attr_o  <= '0;
            stack_attr_o <= '0;
            mode64_o     <= 1'b0;
            cpl_o        <= 2'd0;
            ssp_o        <= '0;
        end else if (commit) begin
            ip_o         <= ip_next;
            flags_o      <= flags_fixed;
            code_sel_o   <= cs_next;
            stack_sel_o  <= ss_next;
            code_attr_o  <= op64_i ? CODE_ATTR_64 : CODE_ATTR_32;
            stack_attr_o <= STACK_ATTR;
            mode64_o     <= op64_i;
            cpl_o        <= 2'd3;
            if (shstk_en_i) ssp_o <= user_ssp_i;
        end
    end
endmodule

// File: rtl/fret_chk.sv
module fret_chk #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48,
    parameter int SEL_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             op64_i,
    input logic [XLEN-1:0]  link_i,
    input logic             done_o,
    input logic             fault_o,
    input logic [XLEN-1:0]  ip_o,
    input logic [XLEN-1:0]  flags_o,
    input logic [SEL_W-1:0] code_sel_o,
    input logic [SEL_W-1:0] stack_sel_o,
    input logic             mode64_o,
    input logic [1:0]       cpl_o,
    input logic [XLEN-1:0]  ssp_o
);
    localparam int HALF = XLEN / 2;

    a_r11_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (done_o ^ fault_o));

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!done_o && !fault_o));

    a_r7_bad_ptr_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op64_i && (link_i[XLEN-1:VA_BITS-1] != '0)
               && (link_i[XLEN-1:VA_BITS-1] != '1)) |=> fault_o);

    a_r7_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(ip_o) && $stable(flags_o) && $stable(code_sel_o)
                     && $stable(stack_sel_o) && $stable(ssp_o) && $stable(cpl_o)));

    a_r4_rpl3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_sel_o[1:0] == 2'b11 && stack_sel_o[1:0] == 2'b11));

    a_r6_forced_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!flags_o[16] && !flags_o[17] && flags_o[1]));

    a_r10_user_level: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cpl_o == 2'd3));

    a_r2_compat_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode64_o) |-> (ip_o[XLEN-1:HALF] == '0));

    a_r8_compat_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !op64_i) |=> done_o);
endmodule

bind fast_return_unit fret_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .op64_i      (op64_i),
    .link_i      (link_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .ip_o        (ip_o),
    .flags_o     (flags_o),
    .code_sel_o  (code_sel_o),
    .stack_sel_o (stack_sel_o),
    .mode64_o    (mode64_o),
    .cpl_o       (cpl_o),
    .ssp_o       (ssp_o)
);

// File: tb/tb_fast_return_unit.sv
module tb_fast_return_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        op64_i = 1'b0;
    logic [63:0] link_i = '0;
    logic [63:0] flags_src_i = '0;
    logic [63:0] sel_cfg_i = '0;
    logic        shstk_en_i = 1'b0;
    logic [63:0] user_ssp_i = '0;
    logic        done_o, fault_o, mode64_o;
    logic [63:0] ip_o, flags_o, ssp_o;
    logic [15:0] code_sel_o, stack_sel_o;
    logic [10:0] code_attr_o, stack_attr_o;
    logic [1:0]  cpl_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit          flt;
        logic [63:0] ip, fl, ssp;
        logic [15:0] cs, ss;
        logic [10:0] ca, sa;
        logic        m64;
        logic [1:0]  cpl;
    } exp_t;

    exp_t q[$];
    exp_t model;

    always #10 clk = ~clk;

    fast_return_unit dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op64_i(op64_i),
        .link_i(link_i), .flags_src_i(flags_src_i), .sel_cfg_i(sel_cfg_i),
        .shstk_en_i(shstk_en_i), .user_ssp_i(user_ssp_i),
        .done_o(done_o), .fault_o(fault_o), .ip_o(ip_o), .flags_o(flags_o),
        .code_sel_o(code_sel_o), .stack_sel_o(stack_sel_o),
        .code_attr_o(code_attr_o), .stack_attr_o(stack_attr_o),
        .mode64_o(mode64_o), .cpl_o(cpl_o), .ssp_o(ssp_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: compute expectation, push it, raise the request for one cycle
    task automatic issue(input bit op64, input logic [63:0] link, input logic [63:0] fsrc,
                         input logic [63:0] cfg, input bit shen, input logic [63:0] ussp);
        exp_t e;
        logic [15:0] base;
        bit canon;
        canon = (link[63:47] == 17'h0) || (link[63:47] == 17'h1FFFF);
        e = model;
        if (op64 && !canon) begin
            e.flt = 1;
        end else begin
            e.flt = 0;
            base  = cfg[63:48];
            e.ip  = op64 ? link : {32'h0, link[31:0]};
            e.fl  = fsrc;
            e.fl[63:22] = '0;
            e.fl[17] = 1'b0; e.fl[16] = 1'b0; e.fl[15] = 1'b0;
            e.fl[5] = 1'b0;  e.fl[3] = 1'b0;  e.fl[1] = 1'b1;
            e.cs  = (op64 ? base + 16'd16 : base) | 16'h3;
            e.ss  = (base + 16'd8) | 16'h3;
            e.ca  = op64 ? 11'h5FB : 11'h6FB;
            e.sa  = 11'h6F3;
            e.m64 = op64;
            e.cpl = 2'd3;
            if (shen) e.ssp = ussp;
            model = e;
        end
        q.push_back(e);
        req_i = 1'b1; op64_i = op64; link_i = link; flags_src_i = fsrc;
        sel_cfg_i = cfg; shstk_en_i = shen; user_ssp_i = ussp;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples 5 ns after each rising edge
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk); #5;
            if (done_o || fault_o) begin
                if (q.size() == 0) begin
                    check(0, "R11 response without request", {62'h0, done_o, fault_o}, 64'h0);
                end else begin
                    e = q.pop_front();
                    check(fault_o == e.flt && done_o == !e.flt, "R11/R7/R8 response kind",
                          {62'h0, done_o, fault_o}, {62'h0, !e.flt, e.flt});
                    check(ip_o == e.ip, "R1/R2 ip", ip_o, e.ip);
                    check(flags_o == e.fl, "R6 flags", flags_o, e.fl);
                    check(code_sel_o == e.cs, "R3/R4 code selector", 64'(code_sel_o), 64'(e.cs));
                    check(stack_sel_o == e.ss, "R3/R4 stack selector", 64'(stack_sel_o), 64'(e.ss));
                    check(code_attr_o == e.ca, "R5 code attr", 64'(code_attr_o), 64'(e.ca));
                    check(stack_attr_o == e.sa, "R5 stack attr", 64'(stack_attr_o), 64'(e.sa));
                    check(mode64_o == e.m64, "R2 mode", 64'(mode64_o), 64'(e.m64));
                    check(cpl_o == e.cpl, "R10 cpl", 64'(cpl_o), 64'(e.cpl));
                    check(ssp_o == e.ssp, "R9 ssp", ssp_o, e.ssp);
                end
            end else if (q.size() != 0) begin
                check(0, "R11 missing response", 64'h0, 64'h1);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        model = '{flt: 0, ip: '0, fl: '0, ssp: '0, cs: '0, ss: '0, ca: '0, sa: '0, m64: 0, cpl: 2'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!done_o && !fault_o, "R12 pulses idle", {62'h0, done_o, fault_o}, 64'h0);
        check(ip_o == 0 && flags_o == 0, "R12 ip/flags zero", ip_o | flags_o, 64'h0);
        check(code_sel_o == 0 && stack_sel_o == 0, "R12 selectors zero",
              64'({code_sel_o, stack_sel_o}), 64'h0);
        check(code_attr_o == 0 && stack_attr_o == 0 && !mode64_o && ssp_o == 0,
              "R12 attrs/mode/ssp zero", ssp_o, 64'h0);
        check(cpl_o == 2'd0, "R10 reset cpl", 64'(cpl_o), 64'h0);

        // R1 R3 R6 R9: 64-bit, canonical low, shadow stack on
        issue(1, 64'h0000_7FFF_FFFF_F000, 64'hFFFF_FFFF_FFFF_FFFF,
              64'h0023_0010_0000_0000, 1, 64'h0000_7FFF_0000_1234);
        idle(2);
        // R2 R8 R9: compat with junk upper link bits, shadow stack off (hold)
        issue(0, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_FFFF_0003_0202,
              64'h0023_0000_0000_0000, 0, 64'h1111_2222_3333_4444);
        idle(2);
        // R7: first non-canonical value above the low half
        issue(1, 64'h0000_8000_0000_0000, 64'h0, 64'h0040_0000_0000_0000, 1, 64'h5555);
        idle(2);
        // R7: just below the high half
        issue(1, 64'hFFFF_7FFF_FFFF_FFFF, 64'h0, 64'h0040_0000_0000_0000, 1, 64'h6666);
        idle(1);
        // R1: lowest canonical high-half address
        issue(1, 64'hFFFF_8000_0000_0000, 64'h0000_0000_0000_0000,
              64'h0050_0000_0000_0000, 1, 64'hAAAA_0000);
        idle(2);
        // R3 R4: selector wraparound
        issue(1, 64'h0000_0000_0040_0000, 64'h0000_0000_0000_8AD7,
              64'hFFF8_0000_0000_0000, 0, 64'h0);
        idle(1);
        issue(0, 64'h0000_0000_8000_0000, 64'h0000_0000_0024_0000,
              64'hFFF8_0000_0000_0000, 1, 64'hBEEF);
        idle(2);
        // R11: back-to-back requests, commit / fault / commit
        issue(1, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0246,
              64'h0018_0000_0000_0000, 1, 64'h100);
        issue(1, 64'h1234_0000_0000_0000, 64'h0, 64'h0018_0000_0000_0000, 1, 64'h200);
        issue(0, 64'h0000_0001_0000_2000, 64'h0000_0000_0001_0246,
              64'h0018_0000_0000_0000, 1, 64'h300);
        idle(4);
        check(q.size() == 0, "R11 all requests answered", 64'(q.size()), 64'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule